// File: doc/BRIEF.md
# Partial Reconfiguration Host Sequencer

This block runs one partial-reconfiguration session at a time against a device configuration controller. A start command raises the request line. While the controller prepares, the outgoing data bus stays at zero. Once the controller shows it is ready, configuration words pass from an upstream valid/ready stream to the controller, one word per clock. The controller reports its state on four lines that are asynchronous to the block's clock: ready, done, error and CRC error. Each line is synchronized before the state machine uses it.

A session ends in one of four ways: success, general error, readback CRC error, or withdrawal by an abort command. When it ends, the block emits a one-cycle finish pulse and holds a two-bit result code until the next session ends. After the request line falls, for any reason, a gap counter blocks a new request for a parameterized number of cycles. A busy flag covers the whole session and the gap that follows it.

Top module: `pr_host_seq`

## Requirements
- R1: When idle with the gap expired, a high `start_i` sampled on a clock edge makes `cfg_req` high from that edge on. `cfg_data` stays zero until streaming begins.
- R2: Each status input passes through a SYNC-stage synchronizer. With SYNC=2, `s_ready` cannot rise within two clock edges of `cfg_ready_a` rising.
- R3: Every upstream word accepted with `s_valid && s_ready` appears on `cfg_data` one cycle later. In any cycle without such a word, including the cycle after the word marked `s_last`, `cfg_data` is zero.
- R4: `s_ready` is high only while streaming, the synchronized ready is high, no synchronized error is seen, and `abort_i` is low. It is never high unless `cfg_req` is high.
- R5: After the last word, synchronized done lowers `cfg_req`. The finish pulse follows when done falls, with result 2'b00 (success).
- R6: On a synchronized error, streaming stops and `cfg_req` stays high until ready falls. `cfg_req` then goes low, and the finish pulse waits until error falls, with result 2'b01 (error).
- R7: If CRC error was seen at any time during the session, the error recovery of R6 ends with result 2'b10 (CRC failure).
- R8: An abort during streaming lowers `cfg_req` on the next edge, and no word is accepted in that cycle. The finish pulse waits for ready to fall, with result 2'b11 (withdrawn).
- R9: An abort received before ready is held pending: `cfg_req` stays high and no word is accepted. When ready appears, the session withdraws as in R8.
- R10: After `cfg_req` falls, at least GAP cycles pass before it rises again. A start issued during the gap is ignored.
- R11: `busy` is high from the accepted start until the session has finished and the gap has expired. `fin` is high for exactly one cycle per session.
- R12: Synchronous active-high `rst` gives `cfg_req` low, `cfg_data` zero, `busy` low, `fin` low and the gap already expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reconfiguration clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a session |
| abort_i | input | 1 | Withdraw the current session |
| s_data | input | DW | Upstream configuration word |
| s_valid | input | 1 | Upstream word valid |
| s_last | input | 1 | Marks the final word |
| s_ready | output | 1 | Upstream word accepted this cycle |
| cfg_req | output | 1 | Request line to the controller |
| cfg_data | output | DW | Data bus to the controller |
| cfg_ready_a | input | 1 | Controller ready, asynchronous |
| cfg_done_a | input | 1 | Controller done, asynchronous |
| cfg_err_a | input | 1 | Controller error, asynchronous |
| cfg_crc_a | input | 1 | Controller CRC error, asynchronous |
| busy | output | 1 | Session or gap in progress |
| fin | output | 1 | One-cycle session-finished pulse |
| result | output | 2 | Outcome code of the last session |

## Verification
The properties check on every cycle:
- the minimum low time of the request line;
- that data is non-zero only one cycle after an accepted word;
- that upstream ready is never high without a request;
- that the finish pulse is one cycle wide and falls inside busy;
- that a request rises only after a start;
- the reset state.

The order of events in each session can only be shown by the directed scenarios, because it depends on how the controller's asynchronous lines are sequenced. These scenarios cover the synchronizer delay, the request held until ready falls after an error, a pending abort, CRC-cause recording, and a start ignored during the gap.

// File: rtl/pr_host_seq.sv
module pr_host_seq #(
  parameter int DW   = 32,
  parameter int GAP  = 10,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [DW-1:0] s_data,
  input  logic          s_valid,
  input  logic          s_last,
  output logic          s_ready,
  output logic          cfg_req,
  output logic [DW-1:0] cfg_data,
  input  logic          cfg_ready_a,
  input  logic          cfg_done_a,
  input  logic          cfg_err_a,
  input  logic          cfg_crc_a,
  output logic          busy,
  output logic          fin,
  output logic [1:0]    result
);
  localparam int GW = $clog2(GAP + 1);
  localparam logic [1:0] RES_OK = 2'd0, RES_ERR = 2'd1, RES_CRC = 2'd2, RES_WD = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_STRM, S_DONE, S_CLOSE, S_EHOLD, S_ECLR, S_WDRAW
  } st_t;

  st_t st, st_n;
  logic [3:0] sy [SYNC];
  logic [GW-1:0] gap_q;
  logic pend, crc_seen, req_n, end_now, fire;
  logic [1:0] res_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < SYNC; k++) sy[k] <= '0;
    end else begin
      sy[0] <= {cfg_crc_a, cfg_err_a, cfg_done_a, cfg_ready_a};
      for (int k = 1; k < SYNC; k++) sy[k] <= sy[k-1];
    end
  end

  wire rdy_s  = sy[SYNC-1][0];
  wire done_s = sy[SYNC-1][1];
  wire err_s  = sy[SYNC-1][2];
  wire crc_s  = sy[SYNC-1][3];

  assign s_ready = (st == S_STRM) && rdy_s && !err_s && !abort_i;
  assign fire    = s_valid && s_ready;
  assign busy    = (st != S_IDLE) || (gap_q != '0);

  always_comb begin
    st_n    = st;
    req_n   = cfg_req;
    end_now = 1'b0;
    res_n   = result;
    case (st)
      S_IDLE:  if (start_i && gap_q == '0) begin st_n = S_REQ; req_n = 1'b1; end
      S_REQ:
        if (err_s) st_n = S_EHOLD;
        else if (rdy_s) begin
          if (pend || abort_i) begin st_n = S_WDRAW; req_n = 1'b0; end
          else st_n = S_STRM;
        end
      S_STRM:
        if (err_s) st_n = S_EHOLD;
        else if (abort_i) begin st_n = S_WDRAW; req_n = 1'b0; end
        else if (fire && s_last) st_n = S_DONE;
      S_DONE:
        if (err_s) st_n = S_EHOLD;
        else if (done_s) begin st_n = S_CLOSE; req_n = 1'b0; end
      S_CLOSE: if (!done_s) begin st_n = S_IDLE; end_now = 1'b1; res_n = RES_OK; end
      S_EHOLD: if (!rdy_s) begin st_n = S_ECLR; req_n = 1'b0; end
      S_ECLR:
        if (!err_s) begin
          st_n = S_IDLE; end_now = 1'b1;
          res_n = crc_seen ? RES_CRC : RES_ERR;
        end
      S_WDRAW: if (!rdy_s) begin st_n = S_IDLE; end_now = 1'b1; res_n = RES_WD; end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cfg_req  <= 1'b0;
      cfg_data <= '0;
      gap_q    <= '0;
      pend     <= 1'b0;
      crc_seen <= 1'b0;
      fin      <= 1'b0;
      result   <= RES_OK;
    end else begin
      st       <= st_n;
      cfg_req  <= req_n;
      cfg_data <= fire ? s_data : '0;
      fin      <= end_now;
      result   <= res_n;
      pend     <= (st == S_REQ) && (pend || abort_i);
      crc_seen <= (st != S_IDLE) && (crc_seen || crc_s);
      if (cfg_req && !req_n) gap_q <= GW'(GAP);
      else if (gap_q != '0)  gap_q <= gap_q - 1'b1;
    end
  end
endmodule

// File: rtl/pr_host_seq_chk.sv
module pr_host_seq_chk #(
  parameter int DW  = 32,
  parameter int GAP = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          s_valid,
  input logic          s_ready,
  input logic          cfg_req,
  input logic [DW-1:0] cfg_data,
  input logic          busy,
  input logic          fin
);
  localparam int CW = $clog2(GAP + 2);
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) low_cnt <= CW'(GAP);
    else if (cfg_req) low_cnt <= '0;
    else if (low_cnt < CW'(GAP)) low_cnt <= low_cnt + 1'b1;
  end

  p_start_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_req) |-> $past(start_i));
  p_zero_data_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_data != '0) |-> $past(s_valid && s_ready));
  p_sready_req_r4: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> cfg_req);
  p_req_gap_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_req) |-> (low_cnt >= CW'(GAP)));
  p_fin_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin);
  p_fin_busy_r11: assert property (@(posedge clk) disable iff (rst)
    fin |-> busy);
  p_reset_r12: assert property (@(posedge clk)
    rst |=> (!cfg_req && cfg_data == '0 && !busy && !fin));
endmodule

bind pr_host_seq pr_host_seq_chk #(.DW(DW), .GAP(GAP)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .s_valid(s_valid), .s_ready(s_ready),
  .cfg_req(cfg_req), .cfg_data(cfg_data), .busy(busy), .fin(fin)
);

// File: tb/test_pr_host_seq.sv
module test_pr_host_seq;
  localparam int DW = 32;
  localparam int GAP = 10;

  logic clk = 1'b0, rst = 1'b1, start_i = 1'b0, abort_i = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic s_valid = 1'b0, s_last = 1'b0;
  logic rdy_a = 1'b0, done_a = 1'b0, err_a = 1'b0, crc_a = 1'b0;
  logic s_ready, cfg_req, busy, fin;
  logic [DW-1:0] cfg_data;
  logic [1:0] result;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pr_host_seq #(.DW(DW), .GAP(GAP), .SYNC(2)) i_pr_host_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .abort_i(abort_i),
    .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
    .cfg_req(cfg_req), .cfg_data(cfg_data),
    .cfg_ready_a(rdy_a), .cfg_done_a(done_a), .cfg_err_a(err_a), .cfg_crc_a(crc_a),
    .busy(busy), .fin(fin), .result(result)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wait_req(input logic v, input int n, input string tag);
    int i = 0;
    while (cfg_req !== v && i < n) begin tick(); i++; end
    chk(cfg_req === v, tag, 64'(cfg_req), 64'(v));
  endtask

  task automatic wait_sready(input int n);
    int i = 0;
    while (s_ready !== 1'b1 && i < n) begin tick(); i++; end
    chk(s_ready === 1'b1, "R4 s_ready while streaming", 64'(s_ready), 1);
  endtask

  task automatic wait_fin(input int n, input logic [1:0] exp, input string tag);
    int i = 0;
    while (fin !== 1'b1 && i < n) begin tick(); i++; end
    chk(fin === 1'b1, {tag, " fin"}, 64'(fin), 1);
    chk(result === exp, {tag, " result"}, 64'(result), 64'(exp));
    tick();
    chk(fin === 1'b0, "R11 fin single cycle", 64'(fin), 0);
  endtask

  task automatic wait_idle();
    int i = 0;
    while (busy && i < 40) begin tick(); i++; end
    chk(!busy, "R11 busy clears after gap", 64'(busy), 0);
  endtask

  task automatic start_session();
    start_i = 1'b1; tick(); start_i = 1'b0;
    chk(cfg_req === 1'b1, "R1 req rises", 64'(cfg_req), 1);
    chk(cfg_data === '0, "R1 data zero", 64'(cfg_data), 0);
    chk(busy === 1'b1, "R11 busy after start", 64'(busy), 1);
  endtask

  task automatic send_words(input int cnt, input logic [DW-1:0] base);
    for (int i = 0; i < cnt; i++) begin
      if (i == 1) begin
        s_valid = 1'b0; tick();
        chk(cfg_data === '0, "R3 bubble zero", 64'(cfg_data), 0);
      end
      s_data = base + DW'(i); s_valid = 1'b1; s_last = (i == cnt - 1);
      tick();
      chk(cfg_data === base + DW'(i), "R3 word passed", 64'(cfg_data), 64'(base + DW'(i)));
    end
    s_valid = 1'b0; s_last = 1'b0; s_data = '0;
    tick();
    chk(cfg_data === '0, "R3 zero after last", 64'(cfg_data), 0);
    chk(s_ready === 1'b0, "R4 no ready after last", 64'(s_ready), 0);
  endtask

  task automatic t_reset();
    repeat (3) tick();
    chk(!cfg_req && cfg_data == '0 && !busy && !fin && !s_ready, "R12 state during reset",
        {cfg_req, busy, fin, s_ready}, 0);
    rst = 1'b0; tick();
    chk(!cfg_req && cfg_data == '0 && !busy && !fin, "R12 state after reset",
        {cfg_req, busy, fin}, 0);
  endtask

  task automatic t_success_and_gap();
    int low = 0;
    bit seen = 1'b0;
    logic [1:0] res = 2'bxx;
    start_session();
    repeat (3) tick();
    chk(cfg_req && cfg_data == '0, "R1 req held, data zero before ready", 64'(cfg_data), 0);
    chk(s_ready === 1'b0, "R4 no ready before controller", 64'(s_ready), 0);
    rdy_a = 1'b1;
    tick(); chk(s_ready === 1'b0, "R2 sync delay edge 1", 64'(s_ready), 0);
    tick(); chk(s_ready === 1'b0, "R2 sync delay edge 2", 64'(s_ready), 0);
    wait_sready(3);
    send_words(4, 32'hA5A5_0010);
    done_a = 1'b1; rdy_a = 1'b0;
    wait_req(1'b0, 6, "R5 req drops on done");
    done_a = 1'b0; start_i = 1'b1;
    while (!cfg_req && low < 40) begin
      if (fin) begin seen = 1'b1; res = result; end
      low++; tick();
    end
    start_i = 1'b0;
    chk(seen && res == 2'b00, "R5 success result", 64'(res), 0);
    chk(cfg_req && low >= GAP, "R10 gap before next request", 64'(low), 64'(GAP));
  endtask

  task automatic t_pending_abort();
    abort_i = 1'b1; tick(); abort_i = 1'b0;
    repeat (3) begin
      tick(); chk(cfg_req === 1'b1, "R9 req held while abort pending", 64'(cfg_req), 1);
    end
    rdy_a = 1'b1;
    repeat (3) begin
      tick(); chk(s_ready === 1'b0, "R9 no streaming after pending abort", 64'(s_ready), 0);
    end
    wait_req(1'b0, 3, "R9 withdraw on ready");
    tick(); chk(fin === 1'b0, "R9 waits for ready low", 64'(fin), 0);
    rdy_a = 1'b0;
    wait_fin(6, 2'b11, "R9");
    wait_idle();
  endtask

  task automatic t_error(input bit crc);
    start_session();
    rdy_a = 1'b1;
    wait_sready(5);
    send_words(2, 32'h0000_7700);
    if (crc) begin crc_a = 1'b1; tick(); end
    err_a = 1'b1;
    repeat (3) tick();
    chk(s_ready === 1'b0, "R6 streaming stops on error", 64'(s_ready), 0);
    repeat (2) begin
      tick(); chk(cfg_req === 1'b1, "R6 req held until ready falls", 64'(cfg_req), 1);
    end
    rdy_a = 1'b0;
    wait_req(1'b0, 6, "R6 req drops after ready");
    repeat (3) begin
      tick(); chk(fin === 1'b0, "R6 no finish while error high", 64'(fin), 0);
    end
    err_a = 1'b0; crc_a = 1'b0;
    wait_fin(6, crc ? 2'b10 : 2'b01, crc ? "R7" : "R6");
    wait_idle();
  endtask

  task automatic t_late_withdraw();
    start_session();
    rdy_a = 1'b1;
    wait_sready(5);
    abort_i = 1'b1; s_valid = 1'b1; s_data = 32'h1234_5678;
    tick();
    abort_i = 1'b0; s_valid = 1'b0; s_data = '0;
    chk(cfg_req === 1'b0, "R8 req drops next edge", 64'(cfg_req), 0);
    chk(cfg_data === '0, "R8 no word taken with abort", 64'(cfg_data), 0);
    repeat (3) begin
      tick(); chk(fin === 1'b0, "R8 waits for ready low", 64'(fin), 0);
    end
    rdy_a = 1'b0;
    wait_fin(6, 2'b11, "R8");
    wait_idle();
  endtask

  task automatic t_start_in_gap();
    start_session();
    rdy_a = 1'b1;
    wait_sready(5);
    abort_i = 1'b1; rdy_a = 1'b0;
    tick(); abort_i = 1'b0;
    wait_fin(6, 2'b11, "R8 quick withdraw");
    start_i = 1'b1; tick(); start_i = 1'b0;
    chk(busy === 1'b1, "R11 busy during gap", 64'(busy), 1);
    repeat (3) begin
      chk(cfg_req === 1'b0, "R10 start ignored in gap", 64'(cfg_req), 0);
      tick();
    end
    wait_idle();
    start_session();
    abort_i = 1'b1; tick(); abort_i = 1'b0;
    rdy_a = 1'b1;
    wait_req(1'b0, 6, "R9 pending abort withdraws");
    rdy_a = 1'b0;
    wait_fin(6, 2'b11, "R9 second");
    wait_idle();
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_success_and_gap();
    t_pending_abort();
    t_error(1'b0);
    t_error(1'b1);
    t_late_withdraw();
    t_start_in_gap();
    repeat (2) tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule